// File: doc/BRIEF.md
# Unaligned Byte-Steering Data Memory Port

This block is the load/store path of a 32-bit scalar core in front of a 4 KB data memory. Each request carries an effective address, an access size (byte, halfword or word), a signedness flag and store data. A load returns a right-aligned 32-bit value one clock later. A store writes exactly the bytes it covers. Any access size may start at any byte address. A word at an odd address completes in the same single request as an aligned one, so no split instruction pair is needed and no alignment trap exists.

The storage is four byte-wide banks, selected by the low two address bits. For every request each bank gets its own row: the base row, or the base row plus one for banks that fall below the start offset. A misaligned access therefore touches each bank at most once in one cycle. The block ignores the address bits above bit 11. An access that runs past the last byte continues at byte zero.

Top module: `unaligned_dmem_port`

## Requirements
- R1: Only bits 11..0 of `req_addr` select a byte; requests whose addresses differ only in bits 31..12 read and write the same bytes.
- R2: A word load (size code 2) at any byte address A returns the bytes at A, A+1, A+2, A+3 big-endian: the byte at A lands in bits 31..24 and the byte at A+3 in bits 7..0.
- R3: A halfword load (size code 1) at any address A returns byte A in bits 15..8 and byte A+1 in bits 7..0. With `req_signed`=1, bits 31..16 copy bit 15; with `req_signed`=0 they are zero.
- R4: A byte load (size code 0) returns the byte in bits 7..0. With `req_signed`=1, bits 31..8 copy bit 7; otherwise they are zero.
- R5: A store of size N bytes at address A writes the low N bytes of `req_wdata`, most significant of them at A, and leaves every other byte of the memory unchanged.
- R6: Byte addresses beyond 0xFFF within one access wrap to 0x000 onward, for loads and stores.
- R7: `rsp_valid` is 1 in exactly the cycle after a load request is accepted (`req_valid`=1, `req_write`=0), and 0 after a store or an idle cycle.
- R8: While `rst_n` is low and after its release, until the first load, `rsp_valid` and `rsp_rdata` are 0.
- R9: Size code 3 behaves exactly as a word access (four bytes).
- R10: A word load ignores `req_signed`.
- R11: `rsp_rdata` holds the last load's value through store and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the response path |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 word |
| req_signed | input | 1 | Sign-extend byte and halfword loads |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Load result valid |
| rsp_rdata | output | 32 | Load result, extended to 32 bits |

## Verification
The bench goes after every start offset 0 to 3 for each size. A design that used the wrong bank row for banks below the offset would return bytes from the previous aligned word. Accesses at 0xFFD to 0xFFF check the wrap; a row counter that carried into a thirteenth bit, or did not wrap, would read or write outside the last row. Halfword and byte loads with the top data bit set separate sign from zero extension, and word loads with the signed flag set must come back unchanged. Stores are followed by loads of the neighbouring bytes, so a write enable left on outside the access shows up as corrupted data next to it. Addresses with junk in the upper bits would alias to the wrong bytes if those bits leaked into row selection.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int BYTES_PER_WORD = 4;
  localparam int WORD_BITS      = 8 * BYTES_PER_WORD;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  // number of bytes touched by an access of the given size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

  // extend a right-aligned raw load value of n bytes to a full word
  function automatic logic [WORD_BITS-1:0] extend_load(input logic [WORD_BITS-1:0] raw,
                                                       input logic [2:0] n,
                                                       input logic sgn);
    case (n)
      3'd1:    extend_load = {{24{sgn & raw[7]}}, raw[7:0]};
      3'd2:    extend_load = {{16{sgn & raw[15]}}, raw[15:0]};
      default: extend_load = raw;
    endcase
  endfunction

  // lane position (0 = most significant byte of the access) of a bank
  function automatic logic [1:0] lane_of_bank(input logic [1:0] bank, input logic [1:0] off);
    lane_of_bank = bank - off;
  endfunction

endpackage

// File: rtl/dmem_lane_map.sv
module dmem_lane_map
  import dmem_pkg::*;
#(
  parameter int ADDR_BITS = 12,
  parameter int NBANK     = BYTES_PER_WORD,
  localparam int OFF_BITS = $clog2(NBANK),
  localparam int ROW_BITS = ADDR_BITS - OFF_BITS
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               valid,
  input  logic                               write,
  input  logic [1:0]                         size,
  input  logic [ADDR_BITS-1:0]               addr,
  input  logic [WORD_BITS-1:0]               wdata,
  output logic [NBANK-1:0][ROW_BITS-1:0]     bank_row,
  output logic [NBANK-1:0]                   bank_use,
  output logic [NBANK-1:0]                   bank_we,
  output logic [NBANK-1:0][7:0]              bank_wbyte
);

  logic [OFF_BITS-1:0] off;
  logic [ROW_BITS-1:0] base_row;
  logic [ROW_BITS-1:0] next_row;
  logic [2:0]          nbytes;

  assign off      = addr[OFF_BITS-1:0];
  assign base_row = addr[ADDR_BITS-1:OFF_BITS];
  assign next_row = base_row + 1'b1;   // wraps past the last row
  assign nbytes   = size_bytes(size);

  for (genvar b = 0; b < NBANK; b++) begin : g_lane
    logic [OFF_BITS-1:0] lane;
    logic [5:0]          shamt;
    logic [WORD_BITS-1:0] shifted;

    assign lane = lane_of_bank(OFF_BITS'(b), off);

    always_comb begin
      bank_use[b] = valid && (3'(lane) < nbytes);
      bank_we[b]  = bank_use[b] && write;
      bank_row[b] = (OFF_BITS'(b) < off) ? next_row : base_row;
      shamt       = 6'(8 * (32'(nbytes) - 32'd1 - 32'(lane)));
      shifted     = wdata >> shamt;
      bank_wbyte[b] = shifted[7:0];
    end

    // R6: a bank's row is the base row or the one after it
    p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (bank_row[b] == base_row) || (bank_row[b] == next_row));
  end

  // R5: a store enables exactly as many banks as its size covers
  p_we_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && write) |-> ($countones(bank_we) == ((size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4)));

  // R5: loads and idle cycles never write
  p_no_we_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && write) |-> (bank_we == '0));

  // R9: the spare size code touches all four banks
  p_wide_is_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == 2'd3) |-> ($countones(bank_use) == NBANK));

endmodule

// File: rtl/dmem_byte_bank.sv
module dmem_byte_bank #(
  parameter int ROW_BITS = 10,
  localparam int ROWS    = 1 << ROW_BITS
)(
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_BITS-1:0] row,
  input  logic [7:0]          wbyte,
  output logic [7:0]          rbyte
);

  logic [7:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[row] <= wbyte;
  end

  assign rbyte = cells[row];

endmodule

// File: rtl/dmem_load_align.sv
module dmem_load_align
  import dmem_pkg::*;
#(
  parameter int NBANK     = BYTES_PER_WORD,
  localparam int OFF_BITS = $clog2(NBANK)
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_fire,
  input  logic [OFF_BITS-1:0]        off,
  input  logic [1:0]                 size,
  input  logic                       sgn,
  input  logic [NBANK-1:0][7:0]      bank_rbyte,
  output logic                       rsp_valid,
  output logic [WORD_BITS-1:0]       rsp_rdata
);

  logic [2:0]           nbytes;
  logic [WORD_BITS-1:0] raw;
  logic [WORD_BITS-1:0] ext;

  assign nbytes = size_bytes(size);

  // gather bytes in address order, first byte ends up most significant
  always_comb begin
    raw = '0;
    for (int k = 0; k < NBANK; k++) begin
      if (3'(k) < nbytes) begin
        raw = {raw[WORD_BITS-9:0], bank_rbyte[OFF_BITS'(off + OFF_BITS'(k))]};
      end
    end
    ext = extend_load(raw, nbytes, sgn);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= ld_fire;
      if (ld_fire) rsp_rdata <= ext;
    end
  end

  // R11: result register only moves after a load
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_fire |=> $stable(rsp_rdata));

endmodule

// File: rtl/unaligned_dmem_port.sv
module unaligned_dmem_port
  import dmem_pkg::*;
#(
  parameter int ADDR_BITS = 12,
  localparam int NBANK    = BYTES_PER_WORD,
  localparam int OFF_BITS = $clog2(NBANK),
  localparam int ROW_BITS = ADDR_BITS - OFF_BITS
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);

  logic [ADDR_BITS-1:0]           eff_addr;
  logic [NBANK-1:0][ROW_BITS-1:0] bank_row;
  logic [NBANK-1:0]               bank_use;
  logic [NBANK-1:0]               bank_we;
  logic [NBANK-1:0][7:0]          bank_wbyte;
  logic [NBANK-1:0][7:0]          bank_rbyte;
  logic                           ld_fire;

  assign eff_addr = req_addr[ADDR_BITS-1:0];   // R1: upper bits dropped
  assign ld_fire  = req_valid && !req_write;

  dmem_lane_map #(.ADDR_BITS(ADDR_BITS), .NBANK(NBANK)) u_lane_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (req_valid),
    .write      (req_write),
    .size       (req_size),
    .addr       (eff_addr),
    .wdata      (req_wdata),
    .bank_row   (bank_row),
    .bank_use   (bank_use),
    .bank_we    (bank_we),
    .bank_wbyte (bank_wbyte)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dmem_byte_bank #(.ROW_BITS(ROW_BITS)) u_bank (
      .clk   (clk),
      .we    (bank_we[b]),
      .row   (bank_row[b]),
      .wbyte (bank_wbyte[b]),
      .rbyte (bank_rbyte[b])
    );
  end

  dmem_load_align #(.NBANK(NBANK)) u_load_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_fire    (ld_fire),
    .off        (eff_addr[OFF_BITS-1:0]),
    .size       (req_size),
    .sgn        (req_signed),
    .bank_rbyte (bank_rbyte),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

  // R7: a load is answered in the next cycle
  p_load_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R7: stores and idle cycles produce no response
  p_store_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R7: any accepted request uses at least one bank
  p_some_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (bank_use != '0));

endmodule

// File: tb/unaligned_dmem_port_bench.sv
module unaligned_dmem_port_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_signed;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0]  refm [4096];
  logic [31:0] last_load = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  unaligned_dmem_port u_unaligned_dmem_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic int nb(input logic [1:0] sz);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] model_load(input int a, input int n, input bit sgn);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) v = (v << 8) | 32'(refm[(a + k) % 4096]);
    if (sgn && n == 1 && v[7])  v = v | 32'hFFFF_FF00;
    if (sgn && n == 2 && v[15]) v = v | 32'hFFFF_0000;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input string req, input bit wr, input logic [1:0] sz, input bit sgn,
                    input logic [31:0] addr, input logic [31:0] wd);
    int a = int'(addr[11:0]);
    int n = nb(sz);
    logic [31:0] exp_data;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = sz; req_signed = sgn;
    req_addr = addr; req_wdata = wd;
    if (wr) begin
      for (int k = 0; k < n; k++) refm[(a + k) % 4096] = wd[8*(n-1-k) +: 8];
      exp_data = last_load;
    end else begin
      exp_data = model_load(a, n, sgn);
      last_load = exp_data;
    end
    @(posedge clk);
    #1;
    req_valid = 0;
    check({req, " R7 valid"}, 32'(rsp_valid), wr ? 32'd0 : 32'd1);
    check(wr ? {req, " R11 hold"} : req, rsp_rdata, exp_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
    req_addr = 0; req_wdata = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset valid", 32'(rsp_valid), 32'd0);
    check("R8 reset data", rsp_rdata, 32'd0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    check("R8 idle after reset", rsp_rdata, 32'd0);

    // fill memory with aligned words
    for (int w = 0; w < 1024; w++) op("R5 fill", 1, 2'd2, 0, 32'(w * 4), $urandom);

    // R2 word loads at every offset
    op("R5 pattern", 1, 2'd2, 0, 32'h100, 32'h8123_4567);
    op("R5 pattern", 1, 2'd2, 0, 32'h104, 32'h89AB_CDEF);
    for (int o = 0; o < 4; o++) op("R2 word offset", 0, 2'd2, 0, 32'(32'h100 + o), 0);
    // R10 word load ignores signed flag
    op("R10 word signed", 0, 2'd2, 1, 32'h101, 0);
    // R3 halfwords signed and unsigned at every offset
    for (int o = 0; o < 4; o++) begin
      op("R3 half zero", 0, 2'd1, 0, 32'(32'h103 + o), 0);
      op("R3 half sign", 0, 2'd1, 1, 32'(32'h103 + o), 0);
    end
    // R4 bytes
    op("R4 byte zero", 0, 2'd0, 0, 32'h100, 0);
    op("R4 byte sign", 0, 2'd0, 1, 32'h100, 0);
    op("R4 byte sign pos", 0, 2'd0, 1, 32'h101, 0);
    // R5 misaligned stores leave neighbours alone
    op("R5 half store", 1, 2'd1, 0, 32'h201, 32'hDEAD_BEEF);
    op("R5 neighbour", 0, 2'd2, 0, 32'h200, 0);
    op("R5 neighbour", 0, 2'd2, 0, 32'h201, 0);
    op("R5 word store", 1, 2'd2, 0, 32'h303, 32'h1122_3344);
    op("R5 neighbour", 0, 2'd2, 0, 32'h300, 0);
    op("R5 neighbour", 0, 2'd2, 0, 32'h304, 0);
    op("R5 byte store", 1, 2'd0, 0, 32'h402, 32'hFFFF_FFA5);
    op("R5 neighbour", 0, 2'd2, 0, 32'h400, 0);
    // R6 wrap
    op("R6 wrap store", 1, 2'd2, 0, 32'hFFE, 32'hCAFE_F00D);
    op("R6 wrap word", 0, 2'd2, 0, 32'hFFD, 0);
    op("R6 wrap word", 0, 2'd2, 0, 32'hFFF, 0);
    op("R6 wrap half", 0, 2'd1, 1, 32'hFFF, 0);
    op("R6 low bytes", 0, 2'd2, 0, 32'h000, 0);
    // R1 upper address bits ignored
    op("R1 alias store", 1, 2'd2, 0, 32'hABCD_E501, 32'h5566_7788);
    op("R1 alias load", 0, 2'd2, 0, 32'h0000_0501, 0);
    op("R1 alias load", 0, 2'd1, 0, 32'hFFFF_F502, 0);
    // R9 size code 3
    op("R9 wide store", 1, 2'd3, 0, 32'h602, 32'h0A0B_0C0D);
    op("R9 wide load", 0, 2'd3, 1, 32'h601, 0);
    // R11 idle cycles hold data
    repeat (3) begin
      @(posedge clk); #1;
      check("R11 idle hold", rsp_rdata, last_load);
      check("R7 idle valid", 32'(rsp_valid), 32'd0);
    end
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ad = $urandom;
      if ((i % 5) == 0) ad[11:0] = 12'hFFC | ad[1:0];
      op("R2 R5 random", ($urandom % 3) == 0, 2'($urandom), 1'($urandom), ad, $urandom);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule